// File: doc/BRIEF.md
# Byte-Order Reversal Execute Unit

This unit decodes a 32-bit single-source instruction word that requests a byte-order reversal, and carries it out on a 64-bit source operand. Two fields of the word control the operation. One field sets the operand width, either 32 or 64 bits. The other sets the size of the containers the operand is split into, either 32 or 64 bits. The byte order is reversed inside each container, and each container is handled on its own. The unit also extracts the two register indices from the word. It reports whether the word belongs to this instruction at all, and whether it is the one illegal field combination.

The surrounding core reads the operand and writes back the result. The core also turns the undefined flag into a trap. The logic is combinational, followed by one output register stage. A word is captured in any cycle where the input valid is high, and the output valid rises on the next clock. The number of cycles does not depend on the data.

Top module: `byte_rev_unit`

## Requirements
- R1: A word is recognised only when these fixed bits match: bit 30 = 1, bit 29 = 0, bits 28:21 = 8'hD6, bits 20:16 = 0, bits 15:12 = 0 and bit 11 = 1 (base pattern 32'h5AC00800). An unrecognised word gives recognised = 0, undefFlag = 0 and a result of zero.
- R2: When bit 31 = 0 and bit 10 = 0, the unit reverses the four bytes of operand bits 31:0 into result bits 31:0, and result bits 63:32 are zero.
- R3: When bit 31 = 1 and bit 10 = 0, the unit reverses the bytes of each 32-bit half of the operand inside that half.
- R4: When bit 31 = 1 and bit 10 = 1, the unit reverses all eight bytes of the operand, so byte 0 swaps with byte 7.
- R5: A recognised word with bit 31 = 0 and bit 10 = 1 gives undefFlag = 1 and a result of zero. undefFlag is never 1 unless recognised is also 1.
- R6: srcIdx is word bits 9:5 and dstIdx is word bits 4:0, both registered together with the result.
- R7: outValid equals inValid delayed by exactly one clock, whatever the operand value. A synchronous active-high reset clears outValid, result, indices and flags.
- R8: While inValid is low, result, indices and flags keep their last captured values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Capture strobe for the word and operand |
| instrWord | input | 32 | Instruction word |
| srcOperand | input | 64 | Source operand value |
| outValid | output | 1 | Registered result valid |
| result | output | 64 | Registered reversal result |
| srcIdx | output | 5 | Registered source register index |
| dstIdx | output | 5 | Registered destination register index |
| recognised | output | 1 | Word matched the fixed encoding bits |
| undefFlag | output | 1 | Word uses the illegal width/container pairing |

## Verification
The assertions check on every cycle that the valid output is delayed by one clock, that held outputs stay stable, and that the indices follow the captured word. They also check that undefined or unrecognised words leave a zero result, and that a 32-bit operation clears the upper word. The reversal in each container can only be shown by the bench's scenarios, which compare results against a byte-by-byte model. This covers the directed corner words and a large random mix that includes words with corrupted fixed bits.

// File: rtl/byte_rev_pkg.sv
package byte_rev_pkg;

  // Reversal variant chosen by the decoder
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,   // no data produced (unrecognised or undefined)
    MODE_HALF = 2'd1,   // 32-bit operand, one 32-bit container
    MODE_PAIR = 2'd2,   // 64-bit operand, two 32-bit containers
    MODE_FULL = 2'd3    // 64-bit operand, one 64-bit container
  } revMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic     capture;
    logic     recognised;
    logic     undef;
    revMode_e mode;
  } ctrlStrobe_t;

endpackage

// File: rtl/byte_rev_ctrl.sv
module byte_rev_ctrl
  import byte_rev_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 5
) (
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobe_t        strobe,
  output logic [IDX_W-1:0]   srcIdxNext,
  output logic [IDX_W-1:0]   dstIdxNext
);

  localparam int WIDE_BIT  = INSTR_W - 1;
  localparam int CONT_BIT  = 2 * IDX_W;
  localparam int FIX_LO    = CONT_BIT + 1;
  localparam int FIX_W     = WIDE_BIT - FIX_LO;
  // Fixed bits 30:11, MSB first: 1, 0, 11010110, 00000, 0000, 1
  localparam logic [FIX_W-1:0] FIX_PATTERN = {1'b1, 1'b0, 8'hD6, 5'b00000, 4'b0000, 1'b1};

  logic wideOp;
  logic bigCont;
  logic matchFix;
  logic illegal;

  always_comb begin
    wideOp   = instrWord[WIDE_BIT];
    bigCont  = instrWord[CONT_BIT];
    matchFix = (instrWord[WIDE_BIT-1:FIX_LO] == FIX_PATTERN);
    illegal  = matchFix && !wideOp && bigCont;

    strobe.capture    = inValid;
    strobe.recognised = matchFix;
    strobe.undef      = illegal;
    if (!matchFix || illegal) begin
      strobe.mode = MODE_NONE;
    end else if (!wideOp) begin
      strobe.mode = MODE_HALF;
    end else if (!bigCont) begin
      strobe.mode = MODE_PAIR;
    end else begin
      strobe.mode = MODE_FULL;
    end

    srcIdxNext = instrWord[2*IDX_W-1:IDX_W];
    dstIdxNext = instrWord[IDX_W-1:0];
  end

endmodule

// File: rtl/byte_rev_dpath.sv
module byte_rev_dpath
  import byte_rev_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [IDX_W-1:0]  srcIdxNext,
  input  logic [IDX_W-1:0]  dstIdxNext,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  srcIdx,
  output logic [IDX_W-1:0]  dstIdx,
  output logic              recognised,
  output logic              undefFlag
);

  localparam int HALF_W     = DATA_W / 2;
  localparam int BYTES_FULL = DATA_W / BYTE_W;
  localparam int BYTES_HALF = HALF_W / BYTE_W;

  logic [DATA_W-1:0] fullRev;
  logic [DATA_W-1:0] pairRev;
  logic [DATA_W-1:0] resultNext;

  // One container spanning the whole operand
  for (genvar b = 0; b < BYTES_FULL; b++) begin : g_full
    assign fullRev[b*BYTE_W +: BYTE_W] = srcOperand[(BYTES_FULL-1-b)*BYTE_W +: BYTE_W];
  end

  // Two independent half-width containers
  for (genvar c = 0; c < 2; c++) begin : g_cont
    for (genvar b = 0; b < BYTES_HALF; b++) begin : g_byte
      assign pairRev[c*HALF_W + b*BYTE_W +: BYTE_W] =
        srcOperand[c*HALF_W + (BYTES_HALF-1-b)*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    unique case (strobe.mode)
      MODE_HALF: resultNext = {{HALF_W{1'b0}}, pairRev[HALF_W-1:0]};
      MODE_PAIR: resultNext = pairRev;
      MODE_FULL: resultNext = fullRev;
      default:   resultNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      result     <= '0;
      srcIdx     <= '0;
      dstIdx     <= '0;
      recognised <= 1'b0;
      undefFlag  <= 1'b0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        result     <= resultNext;
        srcIdx     <= srcIdxNext;
        dstIdx     <= dstIdxNext;
        recognised <= strobe.recognised;
        undefFlag  <= strobe.undef;
      end
    end
  end

endmodule

// File: rtl/byte_rev_unit.sv
module byte_rev_unit
  import byte_rev_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int DATA_W  = 64,
  parameter int BYTE_W  = 8,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [DATA_W-1:0]  srcOperand,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic [IDX_W-1:0]   srcIdx,
  output logic [IDX_W-1:0]   dstIdx,
  output logic               recognised,
  output logic               undefFlag
);

  ctrlStrobe_t        strobe;
  logic [IDX_W-1:0]   srcIdxNext;
  logic [IDX_W-1:0]   dstIdxNext;

  byte_rev_ctrl #(.INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_ctrl (
    .inValid    (inValid),
    .instrWord  (instrWord),
    .strobe     (strobe),
    .srcIdxNext (srcIdxNext),
    .dstIdxNext (dstIdxNext)
  );

  byte_rev_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .srcOperand (srcOperand),
    .srcIdxNext (srcIdxNext),
    .dstIdxNext (dstIdxNext),
    .outValid   (outValid),
    .result     (result),
    .srcIdx     (srcIdx),
    .dstIdx     (dstIdx),
    .recognised (recognised),
    .undefFlag  (undefFlag)
  );

endmodule

// File: rtl/byte_rev_chk.sv
module byte_rev_chk #(
  parameter int INSTR_W = 32,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [INSTR_W-1:0] instrWord,
  input logic               outValid,
  input logic [DATA_W-1:0]  result,
  input logic [IDX_W-1:0]   srcIdx,
  input logic [IDX_W-1:0]   dstIdx,
  input logic               recognised,
  input logic               undefFlag
);

  localparam int HALF_W = DATA_W / 2;

  // R7
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (outValid == $past(inValid)));

  // R5
  undef_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    undefFlag |-> recognised);

  // R5
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    undefFlag |-> (result == '0));

  // R1
  unknown_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !recognised |-> (result == '0 && !undefFlag));

  // R2
  narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !instrWord[INSTR_W-1]) |=> (result[DATA_W-1:HALF_W] == '0));

  // R6
  index_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (srcIdx == $past(instrWord[2*IDX_W-1:IDX_W]) &&
                 dstIdx == $past(instrWord[IDX_W-1:0])));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(result) && $stable(srcIdx) && $stable(dstIdx) &&
                  $stable(recognised) && $stable(undefFlag)));

endmodule

bind byte_rev_unit byte_rev_chk #(.INSTR_W(INSTR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .instrWord  (instrWord),
  .outValid   (outValid),
  .result     (result),
  .srcIdx     (srcIdx),
  .dstIdx     (dstIdx),
  .recognised (recognised),
  .undefFlag  (undefFlag)
);

// File: tb/byte_rev_unit_bench.sv
`timescale 1ns/1ps
module byte_rev_unit_bench;

  localparam logic [31:0] BASE = 32'h5AC00800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [63:0] srcOperand = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  srcIdx;
  logic [4:0]  dstIdx;
  logic        recognised;
  logic        undefFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  byte_rev_unit u_byte_rev_unit (
    .clk(clk), .rst(rst), .inValid(inValid), .instrWord(instrWord),
    .srcOperand(srcOperand), .outValid(outValid), .result(result),
    .srcIdx(srcIdx), .dstIdx(dstIdx), .recognised(recognised), .undefFlag(undefFlag)
  );

  function automatic bit modelMatch(input logic [31:0] w);
    return (w[30] == 1'b1) && (w[29] == 1'b0) && (w[28:21] == 8'hD6) &&
           (w[20:16] == 5'd0) && (w[15:12] == 4'd0) && (w[11] == 1'b1);
  endfunction

  function automatic bit modelUndef(input logic [31:0] w);
    return modelMatch(w) && !w[31] && w[10];
  endfunction

  function automatic logic [63:0] modelResult(input logic [31:0] w, input logic [63:0] op);
    logic [63:0] r = '0;
    int bytesPer;
    int nCont;
    if (!modelMatch(w) || modelUndef(w)) return '0;
    nCont    = (w[31] && !w[10]) ? 2 : 1;
    bytesPer = w[10] ? 8 : 4;
    for (int c = 0; c < nCont; c++)
      for (int b = 0; b < bytesPer; b++)
        r[(c*bytesPer + b)*8 +: 8] = op[(c*bytesPer + bytesPer - 1 - b)*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one word for one cycle, then check at the following negedge
  task automatic apply(input logic [31:0] w, input logic [63:0] op, input string req);
    @(negedge clk);
    inValid = 1'b1; instrWord = w; srcOperand = op;
    @(negedge clk);
    inValid = 1'b0; instrWord = ~w; srcOperand = ~op;
    chk({req, " result"}, result, modelResult(w, op));
    chk("R7 outValid", {63'd0, outValid}, 64'd1);
    chk("R1 recognised", {63'd0, recognised}, {63'd0, modelMatch(w)});
    chk("R5 undef", {63'd0, undefFlag}, {63'd0, modelUndef(w)});
    chk("R6 srcIdx", {59'd0, srcIdx}, {59'd0, w[9:5]});
    chk("R6 dstIdx", {59'd0, dstIdx}, {59'd0, w[4:0]});
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk("R7 reset outValid", {63'd0, outValid}, 64'd0);
    chk("R7 reset result", result, 64'd0);
    chk("R7 reset flags", {62'd0, recognised, undefFlag}, 64'd0);
    rst = 1'b0;

    // R2 narrow: 89ABCDEF -> EFCDAB89, upper zero
    apply(BASE | 32'h0000_0043, 64'h0123456789ABCDEF, "R2");
    chk("R2 value", result, 64'h00000000EFCDAB89);
    // R3 two 32-bit containers
    apply(BASE | 32'h8000_0000 | (5'd31 << 5), 64'h0123456789ABCDEF, "R3");
    chk("R3 value", result, 64'h67452301EFCDAB89);
    // R4 full reversal
    apply(BASE | 32'h8000_0400 | 5'd31, 64'h0123456789ABCDEF, "R4");
    chk("R4 value", result, 64'hEFCDAB8967452301);
    // R5 illegal pairing
    apply(BASE | 32'h0000_0400, 64'hFFFFFFFFFFFFFFFF, "R5");
    chk("R5 flag", {62'd0, recognised, undefFlag}, 64'd3);
    // R1 broken fixed bits
    apply((BASE & ~32'h4000_0000) | 32'h0000_0400, 64'h1122334455667788, "R1");
    apply(BASE | 32'h2000_0000, 64'h1122334455667788, "R1");
    apply(BASE & ~32'h0000_0800, 64'h1122334455667788, "R1");

    // R8 hold with inValid low and changed inputs
    apply(BASE | 32'h8000_0400, 64'hA1B2C3D4E5F60718, "R4");
    keep = result;
    @(negedge clk);
    chk("R8 hold result", result, keep);
    chk("R7 outValid low", {63'd0, outValid}, 64'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [63:0] op;
      w = BASE | ($urandom() & 32'h8000_07FF);
      if (($urandom() % 5) == 0) w = w ^ (32'h1 << (11 + ($urandom() % 21)));
      op = {$urandom(), $urandom()};
      apply(w, op, "R3 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule